// File: doc/BRIEF.md
# Debug Hardware Command Executor

This block sits between a host-side debug link and the target's memory bus. Command bytes arrive one per strobe. The block decodes an opcode and, for read commands, collects a 16-bit address sent most significant byte first. It then reads the target bus by borrowing a cycle from the running CPU and streams the 16-bit result back to the host as two bytes.

The block waits for the CPU to report an idle bus cycle before it issues the access. If the CPU stays busy for too long, the block stalls the CPU with a freeze signal and takes the cycle anyway. The block also handles three other commands: a request to enter background mode, which only works when debugging is enabled, and two commands that turn an acknowledge handshake on and off.

A read command either maps the debug register window into the upper 256 bytes of the address space or leaves it mapped out. The block tells the memory side which of the two applies. Byte reads return their data on the byte lane that matches the address parity.

Top module: `dbg_cmd_exec`

## Requirements
- R1: After reset, mem_req, cpu_freeze, bg_req, ack and rsp_valid are all low, and the handshake is off.
- R2: Opcode 0x90 with dbg_en high raises bg_req and holds it until bg_active is seen high. That same edge gives one ack pulse and drops bg_req. With dbg_en low, the byte is ignored: no bg_req, no ack and no cpu_freeze.
- R3: Opcode 0xD5 turns the handshake on and gives exactly one ack pulse. Opcode 0xD6 turns it off and gives no ack pulse.
- R4: Opcodes 0xE4 (byte, window mapped in), 0xEC (word, window mapped in) and 0xE0 (byte, window mapped out) each take two address bytes, high byte first. mem_win is high for 0xE4 and 0xEC and low for 0xE0. mem_addr is the received address with bit 0 forced to 0, and it is held steady until mem_done.
- R5: A byte read of an odd address returns {8'h00, mem_rdata[7:0]}. A byte read of an even address returns {mem_rdata[15:8], 8'h00}. A word read returns mem_rdata unchanged.
- R6: After the last address byte, the block waits for bus_idle. The first wait cycle with bus_idle high starts the access on the next cycle. If 128 wait cycles pass with bus_idle low, the access starts anyway.
- R7: An access that started after a timeout holds cpu_freeze high for every cycle of mem_req. An access that started in an idle cycle keeps cpu_freeze low in its first cycle and high in each later cycle until mem_done. cpu_freeze is never high without mem_req.
- R8: The cycle after mem_done, rsp_valid is high for two consecutive cycles: first with the result's high byte on rsp_byte, then with its low byte.
- R9: When the handshake is on, a read gives one ack pulse in the cycle its first response byte appears. When the handshake is off, a read gives no ack.
- R10: An unrecognised opcode is dropped, and the next byte is decoded as an opcode. Bytes that arrive while a command is being executed or answered are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Command or address byte |
| dbg_en | input | 1 | Debug firmware enabled |
| bus_idle | input | 1 | CPU leaves the bus free this cycle |
| bg_active | input | 1 | CPU is in background mode |
| mem_done | input | 1 | Read data valid, access complete |
| mem_rdata | input | 16 | Read data word |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Word-aligned read address |
| mem_win | output | 1 | Debug window mapped in for this access |
| cpu_freeze | output | 1 | Stall the CPU |
| bg_req | output | 1 | Background-mode entry request |
| ack | output | 1 | Handshake acknowledge strobe |
| rsp_valid | output | 1 | Response byte strobe |
| rsp_byte | output | 8 | Response byte |

## Verification
The hardest case to reach from the ports is the forced access. bus_idle has to stay low for the whole 128-cycle window, and a stray command byte has to arrive while the block is still waiting. Directed reads hold bus_idle low and send a handshake-enable byte partway through the wait. The bench then confirms there is no acknowledge, the freeze covers the whole access, and the wait lasted exactly the full window. Random reads set bus_idle high only rarely, so some of them run close to the timeout as well.

// File: rtl/dbg_cmd_exec.sv
module dbg_cmd_exec #(
  parameter int STEAL_LIMIT = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [7:0]  cmd_byte,
  input  logic        dbg_en,
  input  logic        bus_idle,
  input  logic        bg_active,
  input  logic        mem_done,
  input  logic [15:0] mem_rdata,
  output logic        mem_req,
  output logic [15:0] mem_addr,
  output logic        mem_win,
  output logic        cpu_freeze,
  output logic        bg_req,
  output logic        ack,
  output logic        rsp_valid,
  output logic [7:0]  rsp_byte
);
  localparam int CW = $clog2(STEAL_LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(STEAL_LIMIT - 1);
  localparam logic [7:0] OP_BGND = 8'h90, OP_HS_ON = 8'hD5, OP_HS_OFF = 8'hD6;
  localparam logic [7:0] OP_RD_BX = 8'hE0, OP_RD_BW = 8'hE4, OP_RD_WW = 8'hEC;

  typedef enum logic [2:0] {S_OP, S_AH, S_AL, S_WAIT, S_ACC, S_R0, S_R1, S_BG} st_t;

  st_t           st;
  logic [7:0]    op_q;
  logic [15:0]   addr_q, rsp_q;
  logic [CW-1:0] cnt_q;
  logic          hs_q, forced_q, first_q, ack_q;

  wire is_read = (cmd_byte == OP_RD_BX) || (cmd_byte == OP_RD_BW) || (cmd_byte == OP_RD_WW);
  wire grant   = (st == S_WAIT) && (bus_idle || cnt_q == LAST);
  wire [15:0] lane = (op_q == OP_RD_WW) ? mem_rdata :
                     addr_q[0] ? {8'h00, mem_rdata[7:0]} : {mem_rdata[15:8], 8'h00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_OP;
      op_q     <= '0;
      addr_q   <= '0;
      rsp_q    <= '0;
      cnt_q    <= '0;
      hs_q     <= 1'b0;
      forced_q <= 1'b0;
      first_q  <= 1'b0;
      ack_q    <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      case (st)
        S_OP: if (cmd_valid) begin
          if (cmd_byte == OP_BGND) begin
            if (dbg_en) st <= S_BG;
          end else if (cmd_byte == OP_HS_ON) begin
            hs_q  <= 1'b1;
            ack_q <= 1'b1;
          end else if (cmd_byte == OP_HS_OFF) begin
            hs_q <= 1'b0;
          end else if (is_read) begin
            op_q <= cmd_byte;
            st   <= S_AH;
          end
        end
        S_AH: if (cmd_valid) begin
          addr_q[15:8] <= cmd_byte;
          st           <= S_AL;
        end
        S_AL: if (cmd_valid) begin
          addr_q[7:0] <= cmd_byte;
          cnt_q       <= '0;
          st          <= S_WAIT;
        end
        S_WAIT: if (grant) begin
          forced_q <= !bus_idle;
          first_q  <= 1'b1;
          st       <= S_ACC;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        S_ACC: begin
          first_q <= 1'b0;
          if (mem_done) begin
            rsp_q <= lane;
            ack_q <= hs_q;
            st    <= S_R0;
          end
        end
        S_R0: st <= S_R1;
        S_R1: st <= S_OP;
        S_BG: if (bg_active) begin
          ack_q <= 1'b1;
          st    <= S_OP;
        end
        default: st <= S_OP;
      endcase
    end
  end

  assign mem_req    = (st == S_ACC);
  assign mem_addr   = {addr_q[15:1], 1'b0};
  assign mem_win    = (op_q != OP_RD_BX);
  assign cpu_freeze = mem_req && (forced_q || !first_q);
  assign bg_req     = (st == S_BG);
  assign ack        = ack_q;
  assign rsp_valid  = (st == S_R0) || (st == S_R1);
  assign rsp_byte   = (st == S_R1) ? rsp_q[7:0] : rsp_q[15:8];

  AST_BG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bg_req) |-> $past(dbg_en)) else $error("bg_req without enable"); // R2
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack) else $error("ack longer than one cycle"); // R3
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_done |=> mem_req && $stable(mem_addr)) else $error("request dropped early"); // R4
  AST_TIMEOUT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT) && !bus_idle && (cnt_q == LAST) |=> cpu_freeze) else $error("no forced freeze"); // R6
  AST_FREEZE_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_freeze |-> mem_req) else $error("freeze outside access"); // R7
  AST_RSP_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |=> rsp_valid) else $error("response byte missing"); // R8
endmodule

// File: tb/tb_dbg_cmd_exec.sv
module tb_dbg_cmd_exec;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, dbg_en = 1'b0, bus_idle = 1'b0, bg_active = 1'b0, mem_done = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic [15:0] mem_rdata = 16'h0000;
  logic mem_req, mem_win, cpu_freeze, bg_req, ack, rsp_valid;
  logic [15:0] mem_addr;
  logic [7:0] rsp_byte;

  always #10 clk = ~clk;

  dbg_cmd_exec dut (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .dbg_en(dbg_en), .bus_idle(bus_idle), .bg_active(bg_active), .mem_done(mem_done),
    .mem_rdata(mem_rdata), .mem_req(mem_req), .mem_addr(mem_addr), .mem_win(mem_win),
    .cpu_freeze(cpu_freeze), .bg_req(bg_req), .ack(ack), .rsp_valid(rsp_valid), .rsp_byte(rsp_byte));

  int checks = 0, fails = 0, cyc = 0;
  int lat_g = 1, idle_mode = 1, reqc = 0;
  int ack_n = 0, frz_n = 0, bg_n = 0, rsp_n = 0, last_req_t = 0;
  int rsp_t[2];
  logic [7:0] rsp_b[2];
  bit hs_model = 1'b0;

  function automatic logic [15:0] mem_word(input logic [15:0] a, input logic win);
    logic [31:0] p;
    if (win && a[15:8] == 8'hFF) return 16'hDB00 ^ {a[7:0], a[7:0]};
    p = a * 32'h2F1B;
    return p[15:0] ^ 16'hC3A5;
  endfunction

  function automatic logic [15:0] exp_read(input logic [7:0] op, input logic [15:0] a);
    logic [15:0] w;
    w = mem_word({a[15:1], 1'b0}, op != 8'hE0);
    if (op == 8'hEC) return w;
    return a[0] ? {8'h00, w[7:0]} : {w[15:8], 8'h00};
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    cyc++;
    if (ack) ack_n++;
    if (cpu_freeze) frz_n++;
    if (bg_req) bg_n++;
    if (mem_req) last_req_t = cyc;
    if (rsp_valid && rsp_n < 2) begin rsp_b[rsp_n] = rsp_byte; rsp_t[rsp_n] = cyc; end
    if (rsp_valid) rsp_n++;
    case (idle_mode)
      0: bus_idle = 1'b0;
      1: bus_idle = 1'b1;
      default: bus_idle = ($urandom % 40) == 0;
    endcase
    if (mem_req) begin
      mem_rdata = mem_word(mem_addr, mem_win);
      mem_done = (reqc == lat_g - 1);
      reqc++;
    end else begin
      reqc = 0;
      mem_done = 1'b0;
    end
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic send(input logic [7:0] b);
    @(negedge clk); cmd_valid = 1'b1; cmd_byte = b;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic clr();
    ack_n = 0; frz_n = 0; bg_n = 0; rsp_n = 0;
  endtask

  task automatic do_read(input logic [7:0] op, input logic [15:0] a, input int lat,
                         input int mode, input bit inject);
    int waits;
    logic [15:0] got, exp;
    lat_g = lat; idle_mode = mode;
    send(op); send(a[15:8]);
    clr();
    send(a[7:0]);
    waits = 0;
    while (!mem_req) begin
      waits++;
      if (inject && waits == 5) begin cmd_valid = 1'b1; cmd_byte = 8'hD5; end
      else cmd_valid = 1'b0;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    while (rsp_n < 2) @(negedge clk);
    repeat (2) @(negedge clk);
    got = {rsp_b[0], rsp_b[1]};
    exp = exp_read(op, a);
    chk(got == exp, "R5", $sformatf("read op %0h addr %0h data", op, a), got, exp);
    chk(rsp_t[0] == last_req_t + 1 && rsp_t[1] == rsp_t[0] + 1, "R8", "response timing",
        rsp_t[1] - rsp_t[0], 1);
    chk(ack_n == (hs_model ? 1 : 0), inject ? "R10" : "R9", "ack count", ack_n, hs_model ? 1 : 0);
    if (mode == 1) begin
      chk(waits == 1, "R6", "idle wait", waits, 1);
      chk(frz_n == lat - 1, "R7", "free-cycle freeze", frz_n, lat - 1);
    end else if (mode == 0) begin
      chk(waits == 128, "R6", "timeout wait", waits, 128);
      chk(frz_n == lat, "R7", "forced freeze", frz_n, lat);
    end else begin
      chk(waits >= 1 && waits <= 128, "R6", "wait bound", waits, 128);
      chk(frz_n <= lat, "R7", "freeze bound", frz_n, lat);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({mem_req, cpu_freeze, bg_req, ack, rsp_valid} == 5'b0, "R1", "reset outputs",
        {mem_req, cpu_freeze, bg_req, ack, rsp_valid}, 0);

    do_read(8'hE4, 16'h1235, 1, 1, 0);
    do_read(8'hE4, 16'h1234, 3, 1, 0);
    do_read(8'hEC, 16'h4000, 2, 0, 0);
    do_read(8'hEC, 16'h4001, 1, 1, 0);
    do_read(8'hE0, 16'hFF03, 1, 1, 0);
    do_read(8'hE4, 16'hFF03, 1, 1, 0);
    do_read(8'hEC, 16'hFF06, 2, 1, 0);
    idle_mode = 1; lat_g = 1;
    send(8'hE4); send(8'hFF); clr(); send(8'h04);
    @(negedge clk);
    chk(mem_req && mem_win && mem_addr == 16'hFF04, "R4", "window and address", mem_addr, 16'hFF04);
    repeat (6) @(negedge clk);
    send(8'hE0); send(8'hFF); clr(); send(8'h05);
    @(negedge clk);
    chk(mem_req && !mem_win && mem_addr == 16'hFF04, "R4", "window out", mem_win, 0);
    repeat (6) @(negedge clk);

    clr(); send(8'hD5); repeat (3) @(negedge clk);
    hs_model = 1'b1;
    chk(ack_n == 1, "R3", "enable ack", ack_n, 1);
    do_read(8'hE4, 16'h2221, 2, 1, 0);
    clr(); send(8'hD6); repeat (3) @(negedge clk);
    hs_model = 1'b0;
    chk(ack_n == 0, "R3", "disable ack", ack_n, 0);
    do_read(8'hEC, 16'h3330, 1, 1, 0);

    dbg_en = 1'b0; clr(); send(8'h90); repeat (10) @(negedge clk);
    chk(bg_n == 0 && ack_n == 0 && frz_n == 0, "R2", "disabled bgnd ignored", bg_n + ack_n + frz_n, 0);
    dbg_en = 1'b1; clr(); send(8'h90); repeat (5) @(negedge clk);
    chk(bg_req == 1'b1, "R2", "bg_req held", bg_req, 1);
    bg_active = 1'b1; repeat (2) @(negedge clk);
    bg_active = 1'b0; @(negedge clk);
    chk(ack_n == 1 && !bg_req, "R2", "bgnd ack", ack_n, 1);
    dbg_en = 1'b0;

    clr(); send(8'h55); repeat (2) @(negedge clk);
    chk(ack_n == 0, "R10", "unknown opcode", ack_n, 0);
    do_read(8'hE4, 16'h0F0F, 1, 1, 0);
    do_read(8'hEC, 16'h5678, 3, 0, 1);
    do_read(8'hE4, 16'h5679, 1, 1, 0);

    for (int i = 0; i < 40; i++) begin
      logic [7:0] op;
      logic [15:0] a;
      int k;
      k = $urandom % 3;
      op = (k == 0) ? 8'hE0 : (k == 1) ? 8'hE4 : 8'hEC;
      a = $urandom;
      if ($urandom % 4 == 0) a[15:8] = 8'hFF;
      do_read(op, a, 1 + ($urandom % 4), 2, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule